// File: doc/BRIEF.md
# Destination Address Filter with Paired Registers

This block decides whether an incoming destination address is accepted. It holds four exact-match filters and one 64-bit hash filter. Each filter is loaded through a simple register write port as two 32-bit halves, a bottom half and a top half. A receive path presents each 48-bit destination address on a parallel bus with a valid strobe. One cycle later the block returns a result strobe. The result carries an exact-match flag with the index of the matching filter, and a separate hash-hit flag.

Software loads the bottom half first and then the top half. A bottom write takes that filter out of service, so no half-written address can ever match. The top write puts the filter back in service. Writes may arrive at any time, including while addresses are being looked up.

The hash filter folds the 48 address bits into a 6-bit index by XOR-ing the eight 6-bit slices of the address. It reports a hit when the table bit at that index is set.

Top module: `addr_filter_top`

## Requirements
- R1: While reset is held and after reset is released, `res_valid_o`, `match_o`, `hash_hit_o` and `match_idx_o` are 0. All exact filters start out of service, so an address of zero does not match. The hash filter starts in service with an all-zero table, so it reports no hits.
- R2: A lookup presented with `da_valid_i` high produces `res_valid_o` high on the next cycle. `match_o` is 1 when an in-service filter holds exactly the 48-bit address, and a single differing bit prevents the match. A filter holds bits 31:0 from its bottom half and bits 47:32 from bits 15:0 of its top half.
- R3: A write to a bottom half takes only that filter out of service. The same address then no longer matches on that filter, and the other filters are unaffected.
- R4: A write to a top half puts that filter back in service. Bits 31:16 of that write data are ignored.
- R5: When several in-service filters match, `match_idx_o` reports the lowest index.
- R6: The hash index is the XOR of address slices [5:0], [11:6], and so on up to [47:42]. `hash_hit_o` equals the table bit at that index. Table bits 31:0 come from the hash bottom half and bits 63:32 from the hash top half.
- R7: A write to the hash bottom half suppresses all hash hits. A write to the hash top half restores them.
- R8: In the cycle after `da_valid_i` is low, `res_valid_o`, `match_o` and `hash_hit_o` are 0.
- R9: `match_idx_o` is 0 whenever `match_o` is 0.
- R10: Register select encoding: `wr_sel_i[0]` is 0 for a bottom half and 1 for a top half. `wr_sel_i[3:1]` values 0 to 3 pick an exact filter and value 4 picks the hash filter. A lookup in the same cycle as a write uses the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 4 | Register select: filter pair and half |
| wr_data_i | input | 32 | Register write data |
| da_valid_i | input | 1 | Destination address valid |
| da_i | input | 48 | Destination address |
| res_valid_o | output | 1 | Lookup result valid |
| match_o | output | 1 | Exact filter match |
| match_idx_o | output | 2 | Index of the lowest matching filter |
| hash_hit_o | output | 1 | Hash filter hit |

## Verification
Several properties are checked on every cycle. The result strobe follows the lookup strobe by one cycle, and all flags stay quiet without it. The index is zero when nothing matches. Any reported exact match or hash hit must come from a filter that was in service at lookup time, based on write-port history alone. Exact-address equality, single-bit misses, lowest-index priority, the XOR fold over all 64 table positions and the ordering of a write against a lookup in the same cycle are shown only by the bench scenarios.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int DEF_N_SPEC     = 4;
  localparam int DEF_ADDR_W     = 48;
  localparam int DEF_REG_W      = 32;
  localparam int DEF_HASH_IDX_W = 6;

  typedef enum logic {
    HALF_BOTTOM = 1'b0,
    HALF_TOP    = 1'b1
  } half_e;
endpackage

// File: rtl/addr_filter_slot.sv
module addr_filter_slot #(
  parameter int ADDR_W = 48,
  parameter int REG_W  = 32,
  localparam int HI_W  = ADDR_W - REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] da_i,
  output logic              hit_o
);
  logic [REG_W-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      armed_q <= 1'b0;
    end else if (wr_lo_i) begin
      lo_q    <= wr_data_i;
      armed_q <= 1'b0;
    end else if (wr_hi_i) begin
      hi_q    <= wr_data_i[HI_W-1:0];
      armed_q <= 1'b1;
    end
  end

  assign hit_o = armed_q && (da_i == {hi_q, lo_q});
endmodule

// File: rtl/addr_filter_hash.sv
module addr_filter_hash #(
  parameter int ADDR_W     = 48,
  parameter int REG_W      = 32,
  parameter int HASH_IDX_W = 6,
  localparam int TBL_W     = 2 * REG_W,
  localparam int CHUNKS    = (ADDR_W + HASH_IDX_W - 1) / HASH_IDX_W,
  localparam int PAD_W     = CHUNKS * HASH_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] da_i,
  output logic              hit_o
);
  logic [TBL_W-1:0]      tbl_q;
  logic                  armed_q;
  logic [PAD_W-1:0]      da_pad;
  logic [HASH_IDX_W-1:0] fold;

  // hash pair comes out of reset in service with an empty table
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q   <= '0;
      armed_q <= 1'b1;
    end else if (wr_lo_i) begin
      tbl_q[REG_W-1:0] <= wr_data_i;
      armed_q          <= 1'b0;
    end else if (wr_hi_i) begin
      tbl_q[TBL_W-1:REG_W] <= wr_data_i;
      armed_q              <= 1'b1;
    end
  end

  assign da_pad = PAD_W'(da_i);

  always_comb begin
    fold = '0;
    for (int c = 0; c < CHUNKS; c++) fold ^= da_pad[c*HASH_IDX_W +: HASH_IDX_W];
  end

  assign hit_o = armed_q && tbl_q[fold];
endmodule

// File: rtl/addr_filter_prio.sv
module addr_filter_prio #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_filter_top.sv
module addr_filter_top
  import addr_filter_pkg::*;
#(
  parameter int N_SPEC     = DEF_N_SPEC,
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int REG_W      = DEF_REG_W,
  parameter int HASH_IDX_W = DEF_HASH_IDX_W,
  parameter int IDX_W      = (N_SPEC > 1) ? $clog2(N_SPEC) : 1,
  parameter int SEL_W      = $clog2(N_SPEC + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              da_valid_i,
  input  logic [ADDR_W-1:0] da_i,
  output logic              res_valid_o,
  output logic              match_o,
  output logic [IDX_W-1:0]  match_idx_o,
  output logic              hash_hit_o
);
  localparam int PAIR_W = SEL_W - 1;

  logic [PAIR_W-1:0] pair;
  half_e             half;
  logic [N_SPEC-1:0] spec_hit;
  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              hash_hit;
  logic              hash_lo_we, hash_hi_we;

  assign pair = wr_sel_i[SEL_W-1:1];
  assign half = half_e'(wr_sel_i[0]);

  for (genvar g = 0; g < N_SPEC; g++) begin : g_slot
    logic lo_we, hi_we;
    assign lo_we = wr_en_i && (pair == PAIR_W'(g)) && (half == HALF_BOTTOM);
    assign hi_we = wr_en_i && (pair == PAIR_W'(g)) && (half == HALF_TOP);

    addr_filter_slot #(
      .ADDR_W (ADDR_W),
      .REG_W  (REG_W)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (lo_we),
      .wr_hi_i   (hi_we),
      .wr_data_i (wr_data_i),
      .da_i      (da_i),
      .hit_o     (spec_hit[g])
    );
  end

  assign hash_lo_we = wr_en_i && (pair == PAIR_W'(N_SPEC)) && (half == HALF_BOTTOM);
  assign hash_hi_we = wr_en_i && (pair == PAIR_W'(N_SPEC)) && (half == HALF_TOP);

  addr_filter_hash #(
    .ADDR_W     (ADDR_W),
    .REG_W      (REG_W),
    .HASH_IDX_W (HASH_IDX_W)
  ) u_hash (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (hash_lo_we),
    .wr_hi_i   (hash_hi_we),
    .wr_data_i (wr_data_i),
    .da_i      (da_i),
    .hit_o     (hash_hit)
  );

  addr_filter_prio #(
    .N     (N_SPEC),
    .IDX_W (IDX_W)
  ) u_prio (
    .hit_i (spec_hit),
    .any_o (any_hit),
    .idx_o (hit_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      match_o     <= 1'b0;
      match_idx_o <= '0;
      hash_hit_o  <= 1'b0;
    end else begin
      res_valid_o <= da_valid_i;
      match_o     <= da_valid_i && any_hit;
      match_idx_o <= (da_valid_i && any_hit) ? hit_idx : '0;
      hash_hit_o  <= da_valid_i && hash_hit;
    end
  end
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk #(
  parameter int N_SPEC = 4,
  parameter int ADDR_W = 48,
  parameter int REG_W  = 32,
  parameter int IDX_W  = 2,
  parameter int SEL_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic              da_valid_i,
  input logic [ADDR_W-1:0] da_i,
  input logic              res_valid_o,
  input logic              match_o,
  input logic [IDX_W-1:0]  match_idx_o,
  input logic              hash_hit_o
);
  localparam int PAIR_W = SEL_W - 1;

  // in-service state seen purely from the write port
  logic [N_SPEC-1:0] spec_on_q, spec_seen_q;
  logic              hash_on_q, hash_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_on_q   <= '0;
      spec_seen_q <= '0;
      hash_on_q   <= 1'b1;
      hash_seen_q <= 1'b1;
    end else begin
      spec_seen_q <= spec_on_q;
      hash_seen_q <= hash_on_q;
      if (wr_en_i) begin
        for (int i = 0; i < N_SPEC; i++)
          if (wr_sel_i[SEL_W-1:1] == PAIR_W'(i)) spec_on_q[i] <= wr_sel_i[0];
        if (wr_sel_i[SEL_W-1:1] == PAIR_W'(N_SPEC)) hash_on_q <= wr_sel_i[0];
      end
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!res_valid_o && !match_o && !hash_hit_o && match_idx_o == '0);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    da_valid_i |=> res_valid_o);

  a_r8_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !da_valid_i |=> !res_valid_o);

  a_r8_quiet_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!match_o && !hash_hit_o));

  a_r9_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (match_idx_o == '0));

  a_r3_match_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> spec_seen_q[match_idx_o]);

  a_r7_hash_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_hit_o |-> hash_seen_q);
endmodule

bind addr_filter_top addr_filter_chk #(
  .N_SPEC (N_SPEC),
  .ADDR_W (ADDR_W),
  .REG_W  (REG_W),
  .IDX_W  (IDX_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .da_valid_i  (da_valid_i),
  .da_i        (da_i),
  .res_valid_o (res_valid_o),
  .match_o     (match_o),
  .match_idx_o (match_idx_o),
  .hash_hit_o  (hash_hit_o)
);

// File: tb/addr_filter_top_test.sv
module addr_filter_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        da_valid_i = 1'b0;
  logic [47:0] da_i = '0;
  logic        res_valid_o, match_o, hash_hit_o;
  logic [1:0]  match_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model, maintained from the requirements
  logic [31:0] m_lo [4];
  logic [15:0] m_hi [4];
  logic        m_on [4];
  logic [63:0] m_hash;
  logic        m_hash_on;

  addr_filter_top uut (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .da_valid_i, .da_i, .res_valid_o, .match_o, .match_idx_o, .hash_hit_o
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] fold(input logic [47:0] a);
    logic [5:0] f = '0;
    for (int c = 0; c < 8; c++) f ^= a[c*6 +: 6];
    return f;
  endfunction

  task automatic model_write(input logic [3:0] sel, input logic [31:0] d);
    int p = int'(sel[3:1]);
    if (p < 4) begin
      if (!sel[0]) begin m_lo[p] = d; m_on[p] = 0; end
      else begin m_hi[p] = d[15:0]; m_on[p] = 1; end
    end else if (p == 4) begin
      if (!sel[0]) begin m_hash[31:0] = d; m_hash_on = 0; end
      else begin m_hash[63:32] = d; m_hash_on = 1; end
    end
  endtask

  task automatic expect_of(input logic [47:0] a, output bit em, output logic [1:0] ei, output bit eh);
    em = 0; ei = 0;
    for (int i = 3; i >= 0; i--)
      if (m_on[i] && a == {m_hi[i], m_lo[i]}) begin em = 1; ei = 2'(i); end
    eh = m_hash_on && m_hash[fold(a)];
  endtask

  task automatic compare(input string tag, input bit em, input logic [1:0] ei, input bit eh);
    check(res_valid_o === 1'b1, {tag, " valid"}, 64'(res_valid_o), 1);
    check(match_o === em, {tag, " match"}, 64'(match_o), 64'(em));
    check(match_idx_o === ei, {tag, " idx"}, 64'(match_idx_o), 64'(ei));
    check(hash_hit_o === eh, {tag, " hash"}, 64'(hash_hit_o), 64'(eh));
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
    model_write(sel, d);
  endtask

  task automatic load(input int p, input logic [47:0] a, input logic [15:0] junk);
    wr(4'((p << 1) | 0), a[31:0]);
    wr(4'((p << 1) | 1), {junk, a[47:32]});
  endtask

  task automatic lookup(input logic [47:0] a, input string tag);
    bit em, eh; logic [1:0] ei;
    @(negedge clk_i);
    da_valid_i = 1; da_i = a;
    expect_of(a, em, ei, eh);
    @(negedge clk_i);
    da_valid_i = 0;
    compare(tag, em, ei, eh);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  logic [47:0] addr [4];

  initial begin
    for (int i = 0; i < 4; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_on[i] = 0; end
    m_hash = 0; m_hash_on = 1;
    addr[0] = 48'h0011_2233_4455;
    addr[1] = 48'hA0B1_C2D3_E4F5;
    addr[2] = 48'h7E00_0000_0001;
    addr[3] = 48'hFFFF_FFFF_FFFE;

    // R1: reset state
    repeat (3) @(negedge clk_i);
    check(!res_valid_o && !match_o && !hash_hit_o && match_idx_o == 0, "R1 in reset",
          {res_valid_o, match_o, hash_hit_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(!res_valid_o && !match_o && !hash_hit_o, "R1 after reset", {res_valid_o, match_o, hash_hit_o}, 0);
    lookup(48'h0, "R1 zero address");
    check(match_o === 0 && hash_hit_o === 0, "R1 out of service", {match_o, hash_hit_o}, 0);

    // R2 / R4: load all four, junk in top upper bits
    for (int p = 0; p < 4; p++) load(p, addr[p], 16'hDEAD ^ 16'(p));
    for (int p = 0; p < 4; p++) begin
      lookup(addr[p], "R2 exact");
      check(match_o === 1 && match_idx_o === 2'(p), "R4 top re-arms, upper bits ignored",
            {match_o, match_idx_o}, {1'b1, 2'(p)});
    end
    for (int b = 0; b < 48; b++) begin
      lookup(addr[2] ^ (48'h1 << b), "R2 single bit miss");
      check(match_o === 0, "R2 single bit miss", 64'(match_o), 0);
    end

    // R8: no lookup, result stays quiet
    @(negedge clk_i);
    check(!res_valid_o && !match_o && !hash_hit_o, "R8 idle", {res_valid_o, match_o, hash_hit_o}, 0);

    // R3: bottom write disarms only that filter
    wr(4'h4, addr[2][31:0]);
    lookup(addr[2], "R3 disarmed");
    check(match_o === 0 && match_idx_o === 0, "R9 idx zero on miss", {match_o, match_idx_o}, 0);
    lookup(addr[1], "R3 neighbour kept");
    lookup(addr[3], "R3 neighbour kept");
    wr(4'h5, 32'h0000_7E00);
    lookup(addr[2], "R4 rearmed");

    // R5: priority
    load(3, addr[1], 16'h0);
    lookup(addr[1], "R5 lowest of 1,3");
    check(match_idx_o === 2'd1, "R5 lowest index", 64'(match_idx_o), 1);
    load(0, addr[1], 16'hFFFF);
    lookup(addr[1], "R5 lowest of 0,1,3");
    check(match_idx_o === 2'd0, "R5 lowest index", 64'(match_idx_o), 0);
    wr(4'h0, addr[1][31:0]);
    lookup(addr[1], "R3 index 0 disarmed");
    check(match_idx_o === 2'd1, "R3 falls to next", 64'(match_idx_o), 1);
    wr(4'h1, {16'h0, addr[1][47:32]});

    // R10: write and lookup in the same cycle use old contents
    begin
      bit em, eh; logic [1:0] ei;
      @(negedge clk_i);
      wr_en_i = 1; wr_sel_i = 4'h0; wr_data_i = 32'h1234_5678;
      da_valid_i = 1; da_i = addr[1];
      expect_of(addr[1], em, ei, eh);
      @(negedge clk_i);
      wr_en_i = 0; da_valid_i = 0;
      model_write(4'h0, 32'h1234_5678);
      compare("R10 same cycle", em, ei, eh);
      check(match_idx_o === 2'd0, "R10 old contents", 64'(match_idx_o), 0);
    end
    lookup(addr[1], "R10 after write");
    wr(4'h1, 32'h0);

    // R6: hash sweep over all 64 indices
    wr(4'h8, 32'hA5C3_0F96);
    wr(4'h9, 32'h3C69_F00D);
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [47:0] a;
        a = {42'(64'h9E37_79B9_7F4A_7C15 * (k + 1) + i), 6'h0};
        a[5:0] = 6'(i) ^ fold(a);
        lookup(a, "R6 hash sweep");
        check(hash_hit_o === m_hash[i], "R6 table bit", 64'(hash_hit_o), 64'(m_hash[i]));
      end
    end

    // R7: hash disarm and rearm
    wr(4'h8, 32'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) begin
      lookup(48'(i), "R7 hash disarmed");
      check(hash_hit_o === 0, "R7 no hits", 64'(hash_hit_o), 0);
    end
    wr(4'h9, 32'h0000_0001);
    lookup(48'd0, "R7 rearmed");
    check(hash_hit_o === 1, "R7 hit restored", 64'(hash_hit_o), 1);
    lookup(48'd32, "R7 rearmed upper");
    check(hash_hit_o === 1, "R7 top half bit 32", 64'(hash_hit_o), 1);

    done = 1;
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule